// File: doc/BRIEF.md
# Inter-Processor Interrupt Send Dispatcher

This block takes send commands from a requesting core, works out which core they are meant for, and turns each one into a single update on the target core's register bank. It handles two kinds of command. An interrupt send sets one status bit in the target's bank. A mailbox send (also the restricted any-send) changes one 32-bit mailbox word of the target, byte by byte. The register banks live outside the block. The dispatcher reaches them through a one-cycle read port and an update bus that carries a core index.

A command is one 64-bit word plus an opcode and an access-width flag. Bits 25..16 hold the target core ID. The ID is looked up in a parameterised table of present cores, and its position in that table becomes the core index on the buses. Bits 4..0 hold the interrupt vector. For mailbox sends, bits 4..2 select one of eight words, and bits 30..27 form a keep-mask per byte. The payload is in bits 63..32. A cleared mask bit lets the matching payload byte replace the old byte. A set bit keeps the old byte. If all four mask bits are clear, the block skips the read and writes the whole payload.

The controller handles one command at a time. It has five states:
- IDLE: ready is high. An accepted command moves it to LOOKUP.
- LOOKUP: the ID match is registered. The next state is DECIDE.
- DECIDE: the command is dropped, reported as an error, or turned into an update. A masked mailbox send instead issues a read and moves to MERGE.
- MERGE: the merged word is written back.
- RESP: the response is given, and the controller returns to IDLE.

Top module: `ipi_send_dispatch`

## Requirements
- R1: After reset `cmd_ready` is 1, and `rd_req`, `upd_valid` and `resp_valid` are 0.
- R2: The target core ID is command bits 25..16. It is matched against the `CORE_IDS` table, and the table position of the match is driven on `upd_core`/`rd_core`. If several entries match, the lowest position wins.
- R3: An interrupt send (`cmd_op`=2'b00, either width) to a present core produces exactly one update with `upd_kind`=0. Its `upd_data` has only bit N set, where N is command bits 4..0.
- R4: A mailbox send (`cmd_op`=2'b01) or any-send (2'b10) with `cmd_wide`=0 is dropped. It causes no read and no update, and its response has `resp_err`=0. Opcode 2'b11 is dropped in the same way.
- R5: A mailbox update with `upd_kind`=1 addresses the word given by command bits 4..2, on `upd_word` and `rd_word`.
- R6: For a wide mailbox send or any-send whose mask bits 30..27 are non-zero, the block reads the old word. Each byte i of the written word is the old byte when mask bit 27+i is 1, and payload byte i (command bits 32+8i+7..32+8i) when it is 0.
- R7: When mask bits 30..27 are all zero, no read is issued and the whole payload is written.
- R8: A non-dropped command whose ID matches no table entry gets `resp_err`=1 and causes no read and no update.
- R9: `cmd_ready` is low from the cycle after acceptance until the response cycle is over. The response appears 3 cycles after acceptance, or 4 when a read is needed.
- R10: A read is followed in the very next cycle by the mailbox write of the same command. No other update comes between them.
- R11: Every accepted command gets exactly one `resp_valid` pulse. An update is always followed in the next cycle by a response with `resp_err`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Dispatcher idle and able to accept |
| cmd_op | input | 2 | 00 interrupt send, 01 mailbox send, 10 any-send, 11 reserved |
| cmd_wide | input | 1 | 1 when the access is 64-bit |
| cmd_data | input | 64 | Command word |
| rd_req | output | 1 | Read request to a mailbox word |
| rd_core | output | IDX_W | Core index for the read |
| rd_word | output | 3 | Mailbox word for the read |
| rd_data | input | 32 | Old word, valid the cycle after `rd_req` |
| upd_valid | output | 1 | Bank update strobe |
| upd_kind | output | 1 | 0 OR into status, 1 write mailbox word |
| upd_core | output | IDX_W | Core index of the update |
| upd_word | output | 3 | Mailbox word of the update |
| upd_data | output | 32 | Status bits or mailbox word |
| resp_valid | output | 1 | Completion pulse |
| resp_err | output | 1 | Decode error (target ID not present) |

## Verification
The checks assume that the bank returns `rd_data` exactly one cycle after `rd_req`. The write that follows a read is correct only if that holds. They also assume that a command is taken only when `cmd_ready` is high. The bench honours both: its bank model registers the read word on the clock edge that sees `rd_req`, and it waits for `cmd_ready` before every handshake. Target IDs are drawn mostly from the present-core table and sometimes as random 10-bit values. Opcode, width flag, mask, word index and don't-care bits are randomised, so drops, errors, direct writes and merges all occur.

// File: rtl/ipi_disp_pkg.sv
package ipi_disp_pkg;
    localparam int WORD_BITS = 32;
    localparam int BYTES     = WORD_BITS / 8;
    localparam int TGT_LSB   = 16;
    localparam int VEC_W     = 5;
    localparam int MASK_LSB  = 27;
    localparam int WSEL_W    = 3;

    typedef enum logic [1:0] {
        OP_IPI  = 2'b00,
        OP_MAIL = 2'b01,
        OP_ANY  = 2'b10,
        OP_RSVD = 2'b11
    } cmd_op_e;

    typedef enum logic {
        UPD_STATUS_SET = 1'b0,
        UPD_MBOX_WRITE = 1'b1
    } upd_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_DECIDE,
        ST_MERGE,
        ST_RESP
    } disp_state_e;
endpackage

// File: rtl/ipi_target_lookup.sv
module ipi_target_lookup #(
    parameter int NUM_CORES = 4,
    parameter int ID_W      = 10,
    parameter int IDX_W     = 2,
    parameter logic [NUM_CORES*ID_W-1:0] CORE_IDS = '0
) (
    input  logic [ID_W-1:0]  id,
    output logic             hit,
    output logic [IDX_W-1:0] idx
);
    logic [NUM_CORES-1:0] match;

    for (genvar g = 0; g < NUM_CORES; g++) begin : g_cmp
        assign match[g] = (CORE_IDS[g*ID_W +: ID_W] == id);
    end

    always_comb begin
        hit = |match;
        idx = '0;
        for (int i = NUM_CORES - 1; i >= 0; i--) begin
            if (match[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/ipi_mbox_merge.sv
module ipi_mbox_merge #(
    parameter int BYTES = 4
) (
    input  logic [BYTES*8-1:0] old_word,
    input  logic [BYTES*8-1:0] new_word,
    input  logic [BYTES-1:0]   keep,
    output logic [BYTES*8-1:0] merged
);
    for (genvar g = 0; g < BYTES; g++) begin : g_byte
        assign merged[g*8 +: 8] = keep[g] ? old_word[g*8 +: 8] : new_word[g*8 +: 8];
    end
endmodule

// File: rtl/ipi_send_dispatch.sv
module ipi_send_dispatch
    import ipi_disp_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int ID_W      = 10,
    parameter logic [NUM_CORES*ID_W-1:0] CORE_IDS = {10'd1023, 10'd256, 10'd17, 10'd3},
    localparam int IDX_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_valid,
    output logic                 cmd_ready,
    input  logic [1:0]           cmd_op,
    input  logic                 cmd_wide,
    input  logic [63:0]          cmd_data,
    output logic                 rd_req,
    output logic [IDX_W-1:0]     rd_core,
    output logic [WSEL_W-1:0]    rd_word,
    input  logic [WORD_BITS-1:0] rd_data,
    output logic                 upd_valid,
    output logic                 upd_kind,
    output logic [IDX_W-1:0]     upd_core,
    output logic [WSEL_W-1:0]    upd_word,
    output logic [WORD_BITS-1:0] upd_data,
    output logic                 resp_valid,
    output logic                 resp_err
);
    disp_state_e            state, state_n;
    cmd_op_e                op_q;
    logic                   wide_q;
    logic [ID_W-1:0]        tgt_q;
    logic [VEC_W-1:0]       low_q;
    logic [BYTES-1:0]       mask_q;
    logic [WORD_BITS-1:0]   pay_q;
    logic                   hit_q, err_q;
    logic [IDX_W-1:0]       idx_q;
    logic                   lk_hit;
    logic [IDX_W-1:0]       lk_idx;
    logic [WORD_BITS-1:0]   merged;
    logic                   drop;
    logic                   unused_cmd_bits;

    assign unused_cmd_bits = ^{cmd_data[31], cmd_data[26], cmd_data[15:VEC_W],
                               cmd_data[TGT_LSB+ID_W +: (26-TGT_LSB-ID_W+1)]};

    ipi_target_lookup #(
        .NUM_CORES(NUM_CORES), .ID_W(ID_W), .IDX_W(IDX_W), .CORE_IDS(CORE_IDS)
    ) lookup_i (
        .id(tgt_q), .hit(lk_hit), .idx(lk_idx)
    );

    ipi_mbox_merge #(.BYTES(BYTES)) merge_i (
        .old_word(rd_data), .new_word(pay_q), .keep(mask_q), .merged(merged)
    );

    // 32-bit mailbox/any sends and the reserved opcode are discarded
    assign drop = (op_q == OP_RSVD) || ((op_q != OP_IPI) && !wide_q);

    assign rd_core  = idx_q;
    assign upd_core = idx_q;
    assign rd_word  = low_q[VEC_W-1 -: WSEL_W];
    assign upd_word = low_q[VEC_W-1 -: WSEL_W];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            op_q   <= OP_IPI;
            wide_q <= 1'b0;
            tgt_q  <= '0;
            low_q  <= '0;
            mask_q <= '0;
            pay_q  <= '0;
            hit_q  <= 1'b0;
            idx_q  <= '0;
            err_q  <= 1'b0;
        end else begin
            state <= state_n;
            if (state == ST_IDLE && cmd_valid) begin
                op_q   <= cmd_op_e'(cmd_op);
                wide_q <= cmd_wide;
                tgt_q  <= cmd_data[TGT_LSB +: ID_W];
                low_q  <= cmd_data[VEC_W-1:0];
                mask_q <= cmd_data[MASK_LSB +: BYTES];
                pay_q  <= cmd_data[63:32];
            end
            if (state == ST_LOOKUP) begin
                hit_q <= lk_hit;
                idx_q <= lk_idx;
            end
            if (state == ST_DECIDE) begin
                err_q <= !drop && !hit_q;
            end
        end
    end

    always_comb begin
        state_n    = state;
        cmd_ready  = 1'b0;
        rd_req     = 1'b0;
        upd_valid  = 1'b0;
        upd_kind   = UPD_STATUS_SET;
        upd_data   = '0;
        resp_valid = 1'b0;
        resp_err   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                cmd_ready = 1'b1;
                if (cmd_valid) state_n = ST_LOOKUP;
            end
            ST_LOOKUP: state_n = ST_DECIDE;
            ST_DECIDE: begin
                state_n = ST_RESP;
                if (!drop && hit_q) begin
                    if (op_q == OP_IPI) begin
                        upd_valid = 1'b1;
                        upd_kind  = UPD_STATUS_SET;
                        upd_data  = WORD_BITS'(1) << low_q;
                    end else if (mask_q == '0) begin
                        upd_valid = 1'b1;
                        upd_kind  = UPD_MBOX_WRITE;
                        upd_data  = pay_q;
                    end else begin
                        rd_req  = 1'b1;
                        state_n = ST_MERGE;
                    end
                end
            end
            ST_MERGE: begin
                upd_valid = 1'b1;
                upd_kind  = UPD_MBOX_WRITE;
                upd_data  = merged;
                state_n   = ST_RESP;
            end
            ST_RESP: begin
                resp_valid = 1'b1;
                resp_err   = err_q;
                state_n    = ST_IDLE;
            end
            default: state_n = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/ipi_send_dispatch_chk.sv
module ipi_send_dispatch_chk #(
    parameter int WORD_BITS = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cmd_valid,
    input logic                 cmd_ready,
    input logic                 rd_req,
    input logic                 upd_valid,
    input logic                 upd_kind,
    input logic [WORD_BITS-1:0] upd_data,
    input logic                 resp_valid,
    input logic                 resp_err
);
    a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> !cmd_ready);

    a_r11_ready_after_resp: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> cmd_ready);

    a_r3_status_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !upd_kind) |-> $onehot(upd_data));

    a_r10_merge_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> (upd_valid && upd_kind && !rd_req));

    a_r11_update_then_ok: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |=> (resp_valid && !resp_err));

    a_r8_err_without_update: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_err) |-> (!$past(upd_valid) && !$past(rd_req)));

    a_r9_no_update_while_idle: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> !(upd_valid || rd_req || resp_valid));
endmodule

bind ipi_send_dispatch ipi_send_dispatch_chk #(.WORD_BITS(32)) chk_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .rd_req(rd_req), .upd_valid(upd_valid), .upd_kind(upd_kind),
    .upd_data(upd_data), .resp_valid(resp_valid), .resp_err(resp_err)
);

// File: tb/ipi_send_dispatch_tb_top.sv
`timescale 1ns/1ps
module ipi_send_dispatch_tb_top;
    localparam int NC = 4;
    localparam logic [39:0] IDS = {10'd1023, 10'd256, 10'd17, 10'd3};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [1:0]  cmd_op = 2'b00;
    logic        cmd_wide = 1'b0;
    logic [63:0] cmd_data = '0;
    logic        rd_req;
    logic [1:0]  rd_core;
    logic [2:0]  rd_word;
    logic [31:0] rd_data = '0;
    logic        upd_valid;
    logic        upd_kind;
    logic [1:0]  upd_core;
    logic [2:0]  upd_word;
    logic [31:0] upd_data;
    logic        resp_valid;
    logic        resp_err;

    int checks = 0;
    int fails  = 0;
    int upd_cnt = 0;
    int rd_cnt  = 0;

    logic [31:0] bank_mbox [NC][8];
    logic [31:0] bank_stat [NC];
    logic [31:0] exp_mbox  [NC][8];
    logic [31:0] exp_stat  [NC];

    always #4 clk = ~clk;

    ipi_send_dispatch dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_wide(cmd_wide), .cmd_data(cmd_data),
        .rd_req(rd_req), .rd_core(rd_core), .rd_word(rd_word), .rd_data(rd_data),
        .upd_valid(upd_valid), .upd_kind(upd_kind), .upd_core(upd_core),
        .upd_word(upd_word), .upd_data(upd_data),
        .resp_valid(resp_valid), .resp_err(resp_err)
    );

    function automatic logic [31:0] seed_word(int c, int w);
        return 32'h9E37_79B9 * 32'(c * 8 + w + 1);
    endfunction

    // bank model: one-cycle read, update applied at the clock edge
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < NC; c++) begin
                bank_stat[c] <= '0;
                for (int w = 0; w < 8; w++) bank_mbox[c][w] <= seed_word(c, w);
            end
        end else begin
            if (rd_req) begin
                rd_data <= bank_mbox[rd_core][rd_word];
                rd_cnt  <= rd_cnt + 1;
            end
            if (upd_valid) begin
                upd_cnt <= upd_cnt + 1;
                if (upd_kind) bank_mbox[upd_core][upd_word] <= upd_data;
                else          bank_stat[upd_core] <= bank_stat[upd_core] | upd_data;
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] mk(logic [9:0] id, logic [4:0] low, logic [3:0] mask,
                                       logic [31:0] pay, logic [15:0] junk);
        return {pay, junk[0], mask, junk[1], id, junk[12:2], low};
    endfunction

    task automatic run_cmd(input logic [1:0] op, input logic wide, input logic [63:0] d);
        int idx = 0;
        bit hit = 0;
        bit drop, doit, exp_err, need_rd;
        int lat;
        int u0, r0;
        int bad;
        logic [3:0] mask;
        string req;
        for (int i = NC - 1; i >= 0; i--)
            if (IDS[i*10 +: 10] == d[25:16]) begin idx = i; hit = 1; end
        mask    = d[30:27];
        drop    = (op == 2'b11) || (op != 2'b00 && !wide);
        doit    = !drop && hit;
        exp_err = !drop && !hit;
        need_rd = doit && op != 2'b00 && mask != 4'b0;
        if (doit && op == 2'b00) begin
            exp_stat[idx] = exp_stat[idx] | (32'd1 << d[4:0]);
            req = "R3";
        end else if (doit) begin
            for (int b = 0; b < 4; b++)
                if (!mask[b]) exp_mbox[idx][d[4:2]][b*8 +: 8] = d[32 + b*8 +: 8];
            req = (mask == 4'b0) ? "R7" : "R6";
        end else req = drop ? "R4" : "R8";

        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_wide = wide; cmd_data = d;
        while (!cmd_ready) @(negedge clk);
        u0 = upd_cnt; r0 = rd_cnt;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_data = '1;
        lat = 1;
        while (!resp_valid && lat < 20) begin @(negedge clk); lat++; end
        check(resp_valid && resp_err == exp_err, exp_err ? "R8" : "R11", "resp_err",
              {63'd0, resp_err}, {63'd0, exp_err});
        check(lat == (need_rd ? 4 : 3), "R9", "latency", 64'(lat), need_rd ? 64'd4 : 64'd3);
        check(upd_cnt - u0 == (doit ? 1 : 0), doit ? "R11" : "R4", "update count",
              64'(upd_cnt - u0), doit ? 64'd1 : 64'd0);
        check(rd_cnt - r0 == (need_rd ? 1 : 0), need_rd ? "R6" : "R7", "read count",
              64'(rd_cnt - r0), need_rd ? 64'd1 : 64'd0);
        bad = 0;
        for (int c = 0; c < NC; c++) begin
            if (bank_stat[c] !== exp_stat[c]) bad++;
            for (int w = 0; w < 8; w++) if (bank_mbox[c][w] !== exp_mbox[c][w]) bad++;
        end
        // R2 R5: wrong core or word shows up as a bank mismatch
        check(bad == 0, req, "bank mismatches (R2/R5 routing)", 64'(bad), 64'd0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin : stim
        void'($urandom(32'd20240611));
        for (int c = 0; c < NC; c++) begin
            exp_stat[c] = '0;
            for (int w = 0; w < 8; w++) exp_mbox[c][w] = seed_word(c, w);
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(cmd_ready === 1'b1, "R1", "cmd_ready in reset", {63'd0, cmd_ready}, 64'd1);
        check({rd_req, upd_valid, resp_valid} === 3'b000, "R1", "strobes in reset",
              64'({rd_req, upd_valid, resp_valid}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(cmd_ready === 1'b1 && !upd_valid && !resp_valid, "R1", "idle after reset",
              {63'd0, cmd_ready}, 64'd1);

        // directed corner cases
        run_cmd(2'b00, 1'b0, mk(10'd1023, 5'd31, 4'h0, 32'h0, 16'hFFFF)); // R3 top vector
        run_cmd(2'b00, 1'b1, mk(10'd3, 5'd0, 4'hF, 32'hFFFF_FFFF, 16'h0)); // R3 vector 0
        run_cmd(2'b01, 1'b1, mk(10'd17, 5'd28, 4'h0, 32'hCAFE_F00D, 16'h1234)); // R7 word 7
        run_cmd(2'b01, 1'b1, mk(10'd256, 5'd4, 4'hF, 32'h1111_2222, 16'h0)); // R6 keep all
        run_cmd(2'b01, 1'b1, mk(10'd256, 5'd8, 4'h5, 32'hA1B2_C3D4, 16'h0)); // R6 alternating
        run_cmd(2'b10, 1'b1, mk(10'd3, 5'd12, 4'h8, 32'h5566_7788, 16'h0)); // any-send R6
        run_cmd(2'b01, 1'b0, mk(10'd17, 5'd0, 4'h0, 32'hDEAD_BEEF, 16'h0)); // R4 narrow
        run_cmd(2'b11, 1'b1, mk(10'd17, 5'd0, 4'h0, 32'hDEAD_BEEF, 16'h0)); // R4 reserved
        run_cmd(2'b00, 1'b1, mk(10'd5, 5'd3, 4'h0, 32'h0, 16'h0));          // R8 absent id
        run_cmd(2'b01, 1'b1, mk(10'd4, 5'd0, 4'h3, 32'h0, 16'h0));          // R8 mail absent

        // constrained random mix
        for (int n = 0; n < 300; n++) begin
            logic [9:0] id;
            logic [1:0] op;
            logic wide;
            if ($urandom_range(9) < 8) id = IDS[$urandom_range(NC-1)*10 +: 10];
            else                       id = 10'($urandom);
            op   = ($urandom_range(9) < 9) ? 2'($urandom_range(2)) : 2'b11;
            wide = ($urandom_range(9) < 8);
            run_cmd(op, wide, mk(id, 5'($urandom), 4'($urandom), $urandom, 16'($urandom)));
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule